// File: doc/BRIEF.md
# Multi-Level Indirect Memory Access Unit

This block executes one memory-class command at a time on behalf of a processor datapath. The command set has four operations: load, store, increment and decrement. Each command also carries a 2-bit indirection depth, a 16-bit address/immediate field, store data and the current index-register value. Depending on the depth, the unit follows zero, one or two pointers through memory before it reaches the word to operate on. It then reads that word, writes it, or reads, modifies and writes it back.

Depth 0 has its own meaning for each operation. A load returns the sign-extended field as an immediate. An increment or decrement adjusts the index-register value and does not touch memory. A store at depth 0 is flagged as illegal. All memory traffic goes through one request/ready port. Completion is marked by a single-cycle done pulse, and the value for the destination or index register is presented on that cycle.

Top module: `indirect_access_unit`

## Requirements
- R1: After synchronous reset, busy, done, mem_req and illegal are all low.
- R2: A load (op code 0) at depth 0 returns the 16-bit field sign-extended to 32 bits as its result. It makes no memory transaction.
- R3: At depth 1, the first memory request is addressed to the field sign-extended to 32 bits (field 0xFFF0 gives address 0xFFFFFFF0).
- R4: Depth 2 performs one pointer read and depth 3 performs two. Each word that is read becomes the next address. The final access uses the last pointer read.
- R5: A store (op code 1) at depth 1 to 3 writes the store data to the resolved address with exactly one write. It performs no reads other than the pointer reads.
- R6: An increment (op code 2) or decrement (op code 3) at depth 0 returns the index value plus or minus one, wrapping modulo 2^32. It makes no memory transaction.
- R7: An increment or decrement at depth 1 to 3 reads the resolved word and writes back that word plus or minus one (modulo 2^32) to the same address. The result is the new word.
- R8: A store at depth 0 raises illegal together with done and makes no memory transaction.
- R9: While mem_req is high and mem_ready is low, the request is held on the next cycle with the same address, write enable and write data.
- R10: done is high for exactly one cycle per command. illegal is high only while done is high. A load at depth 1 to 3 returns the final word read.
- R11: A command is accepted only while busy is low. cmd_valid asserted while busy has no effect on memory or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | 0 load, 1 store, 2 increment, 3 decrement |
| cmd_lvl | input | 2 | Indirection depth 0..3 |
| cmd_field | input | 16 | Address or immediate field |
| cmd_wdata | input | 32 | Store data |
| idx_in | input | 32 | Current index-register value |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value for the destination or index register, valid with done |
| illegal | output | 1 | Illegal-command flag, high only with done |

## Verification
The hardest situation to reach is a depth-3 read-modify-write in which every pointer hop and the write-back stall on a slow memory while the addresses are sign-extended negatives. The bench sweeps every operation and every depth against memory latencies of zero, one and two wait cycles. It uses two field sets, one positive and one negative, and pre-loads a distinct pointer chain for each command. Index and data values of 0 and all-ones push increment and decrement through their wrap points. A final command holds cmd_valid high with a conflicting store while the unit is busy, to show that the second command is not taken.

// File: rtl/miu_pkg.sv
package miu_pkg;

    parameter int MIU_DW = 32;
    parameter int MIU_FW = 16;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_INC   = 2'd2,
        OP_DEC   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PTR  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_FIN  = 3'd4
    } st_e;

    // Plan produced when a command is accepted
    typedef struct packed {
        st_e               first;
        logic [1:0]        hops;
        logic [MIU_DW-1:0] addr;
        logic [MIU_DW-1:0] imm;
        logic              bad;
    } plan_t;

    function automatic logic [MIU_DW-1:0] widen_field(input logic [MIU_FW-1:0] f);
        return {{(MIU_DW-MIU_FW){f[MIU_FW-1]}}, f};
    endfunction

    function automatic logic is_mem_state(input st_e s);
        return (s == ST_PTR) || (s == ST_RD) || (s == ST_WR);
    endfunction

endpackage

// File: rtl/miu_step.sv
module miu_step #(
    parameter int DW = miu_pkg::MIU_DW
) (
    input  logic [DW-1:0] a,
    input  logic          down,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        if (down) y = a - ONE;
        else      y = a + ONE;
    end
endmodule

// File: rtl/miu_decode.sv
module miu_decode
    import miu_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [1:0]        lvl,
    input  logic [MIU_FW-1:0] field,
    input  logic [MIU_DW-1:0] idx,
    output plan_t             plan
);
    op_e               op_t;
    logic [MIU_DW-1:0] idx_step;

    assign op_t = op_e'(op);

    miu_step #(.DW(MIU_DW)) u_idx_step (
        .a    (idx),
        .down (op_t == OP_DEC),
        .y    (idx_step)
    );

    always_comb begin
        plan       = '0;
        plan.first = ST_FIN;
        plan.addr  = widen_field(field);
        if (lvl == 2'd0) begin
            plan.hops = 2'd0;
            unique case (op_t)
                OP_LOAD:  plan.imm = widen_field(field);
                OP_INC,
                OP_DEC:   plan.imm = idx_step;
                OP_STORE: plan.bad = 1'b1;
                default:  plan.imm = '0;
            endcase
        end else begin
            plan.hops = lvl - 2'd1;
            if (plan.hops != 2'd0)
                plan.first = ST_PTR;
            else if (op_t == OP_STORE)
                plan.first = ST_WR;
            else
                plan.first = ST_RD;
        end
    end
endmodule

// File: rtl/miu_seq.sv
module miu_seq
    import miu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [MIU_DW-1:0] sdata,
    input  plan_t             plan,
    input  logic [MIU_DW-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MIU_DW-1:0] mem_addr,
    output logic [MIU_DW-1:0] mem_wdata,
    output logic              done,
    output logic [MIU_DW-1:0] result,
    output logic              illegal
);
    st_e               st;
    op_e               op_q;
    logic [1:0]        hops_q;
    logic [MIU_DW-1:0] addr_q;
    logic [MIU_DW-1:0] wdata_q;
    logic [MIU_DW-1:0] res_q;
    logic              bad_q;
    logic [MIU_DW-1:0] word_step;

    miu_step #(.DW(MIU_DW)) u_word_step (
        .a    (mem_rdata),
        .down (op_q == OP_DEC),
        .y    (word_step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            op_q    <= OP_LOAD;
            hops_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_e'(op);
                        hops_q  <= plan.hops;
                        addr_q  <= plan.addr;
                        wdata_q <= sdata;
                        res_q   <= plan.imm;
                        bad_q   <= plan.bad;
                        st      <= plan.first;
                    end
                end
                ST_PTR: begin
                    if (mem_ready) begin
                        addr_q <= mem_rdata;
                        hops_q <= hops_q - 2'd1;
                        if (hops_q == 2'd1)
                            st <= (op_q == OP_STORE) ? ST_WR : ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ready) begin
                        if (op_q == OP_LOAD) begin
                            res_q <= mem_rdata;
                            st    <= ST_FIN;
                        end else begin
                            res_q   <= word_step;
                            wdata_q <= word_step;
                            st      <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (mem_ready) st <= ST_FIN;
                end
                ST_FIN: begin
                    bad_q <= 1'b0;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign mem_req   = is_mem_state(st);
    assign mem_we    = (st == ST_WR);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign done      = (st == ST_FIN);
    assign illegal   = (st == ST_FIN) && bad_q;
    assign result    = res_q;
endmodule

// File: rtl/indirect_access_unit.sv
module indirect_access_unit
    import miu_pkg::*;
#(
    parameter int DW = MIU_DW,
    parameter int FW = MIU_FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [1:0]    cmd_lvl,
    input  logic [FW-1:0] cmd_field,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] idx_in,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          illegal
);
    plan_t plan;
    logic  start;

    assign start = cmd_valid && !busy;

    miu_decode u_dec (
        .op    (cmd_op),
        .lvl   (cmd_lvl),
        .field (cmd_field),
        .idx   (idx_in),
        .plan  (plan)
    );

    miu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (cmd_op),
        .sdata     (cmd_wdata),
        .plan      (plan),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .result    (result),
        .illegal   (illegal)
    );
endmodule

// File: rtl/miu_chk.sv
module miu_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          done,
    input logic          illegal
);
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    flag_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    // R11
    req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R10
    quiet_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_req && busy));

    // R9
    we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);
endmodule

bind indirect_access_unit miu_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_indirect_access_unit.sv
`timescale 1ns/1ps
module sim_indirect_access_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [1:0]  cmd_lvl = '0;
    logic [15:0] cmd_field = '0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] idx_in = '0;
    logic        busy, mem_req, mem_we, done, illegal;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, result;
    logic        mem_ready;

    always #2.5 clk = ~clk;

    indirect_access_unit u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_lvl(cmd_lvl), .cmd_field(cmd_field), .cmd_wdata(cmd_wdata),
        .idx_in(idx_in), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .result(result), .illegal(illegal)
    );

    // memory model: 256 words indexed by address[7:0]
    logic [31:0] mem [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_a = '0;
    logic [31:0] poke_d = '0;
    int          lat = 0;
    int          wcnt = 0;
    logic        cnt_clr = 1'b0;
    int          n_rd = 0, n_wr = 0;
    logic        got_first = 1'b0;
    logic [31:0] first_addr = '0;

    assign mem_ready = mem_req && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        else if (mem_req && mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
        if (!mem_req || mem_ready) wcnt <= 0; else wcnt <= wcnt + 1;
        if (cnt_clr) begin
            n_rd <= 0; n_wr <= 0; got_first <= 1'b0;
        end else begin
            if (mem_req && mem_ready && !mem_we) n_rd <= n_rd + 1;
            if (mem_req && mem_ready && mem_we)  n_wr <= n_wr + 1;
            if (mem_req && !got_first) begin
                got_first  <= 1'b1;
                first_addr <= mem_addr;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    logic        r_done, r_ill, r_done_after, r_busy_after;
    logic [31:0] r_res;

    task automatic run_cmd(input logic [1:0] op, input logic [1:0] lvl, input logic [15:0] fld,
                           input logic [31:0] wd, input logic [31:0] idx, input bit hold);
        int t;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_lvl = lvl; cmd_field = fld;
        cmd_wdata = wd; idx_in = idx; cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        if (hold) begin
            cmd_op = 2'd1; cmd_lvl = 2'd1; cmd_field = 16'h0030; cmd_wdata = 32'hDEAD_BEEF;
        end else begin
            cmd_valid = 1'b0;
        end
        t = 0;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
        end
        r_done = done; r_res = result; r_ill = illegal;
        cmd_valid = 1'b0;
        @(negedge clk);
        r_done_after = done; r_busy_after = busy;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1
        chk(!busy, "R1 busy", {31'b0, busy}, 32'h0);
        chk(!done, "R1 done", {31'b0, done}, 32'h0);
        chk(!mem_req, "R1 mem_req", {31'b0, mem_req}, 32'h0);
        chk(!illegal, "R1 illegal", {31'b0, illegal}, 32'h0);
        rst = 1'b0;

        for (int set = 0; set < 2; set++) begin
            for (int l = 0; l < 3; l++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int v = 0; v < 4; v++) begin
                        logic [1:0]  op, lv;
                        logic [15:0] fld;
                        logic [7:0]  fidx, tgt;
                        logic [31:0] p1, p2, d, idx, wd, old, exp_mem, exp_res, sx;
                        int          exp_rd, exp_wr, it;
                        it   = ((set * 3 + l) * 4 + o) * 4 + v;
                        op   = 2'(o);
                        lv   = 2'(v);
                        lat  = l;
                        fld  = set ? 16'hFFF0 : 16'h0010;
                        fidx = fld[7:0];
                        sx   = {{16{fld[15]}}, fld};
                        p1   = 32'h40 + 32'(set);
                        p2   = 32'h80 + 32'(set);
                        d    = set ? 32'hFFFF_FFFF : 32'h1234_5678 + 32'(it);
                        idx  = set ? 32'hFFFF_FFFF : 32'h0;
                        wd   = 32'hA5A5_0000 + 32'(it);
                        poke(fidx, p1);
                        poke(p1[7:0], p2);
                        poke(p2[7:0], d);
                        tgt = (v == 1) ? fidx : (v == 2) ? p1[7:0] : p2[7:0];
                        old = (v == 1) ? p1 : (v == 2) ? p2 : d;
                        exp_rd = (v == 0) ? 0 : (v - 1) + ((o != 1) ? 1 : 0);
                        exp_wr = (v == 0) ? 0 : ((o != 0) ? 1 : 0);
                        case (o)
                            0: exp_mem = old;
                            1: exp_mem = wd;
                            2: exp_mem = old + 32'd1;
                            default: exp_mem = old - 32'd1;
                        endcase
                        if (v == 0)
                            exp_res = (o == 0) ? sx : (o == 2) ? idx + 32'd1 : idx - 32'd1;
                        else
                            exp_res = exp_mem;
                        run_cmd(op, lv, fld, wd, idx, 1'b0);
                        chk(r_done, "R10 done seen", {31'b0, r_done}, 32'h1);
                        chk(!r_done_after, "R10 done one cycle", {31'b0, r_done_after}, 32'h0);
                        chk(!r_busy_after, "R11 idle after done", {31'b0, r_busy_after}, 32'h0);
                        chk(r_ill == (o == 1 && v == 0), "R8 illegal flag", {31'b0, r_ill},
                            {31'b0, (o == 1 && v == 0)});
                        chk(n_rd == exp_rd, "R4 read count", 32'(n_rd), 32'(exp_rd));
                        chk(n_wr == exp_wr, "R5 write count", 32'(n_wr), 32'(exp_wr));
                        if (o != 1) begin
                            if (v == 0 && o == 0) chk(r_res == exp_res, "R2 immediate", r_res, exp_res);
                            else if (v == 0)      chk(r_res == exp_res, "R6 index step", r_res, exp_res);
                            else if (o == 0)      chk(r_res == exp_res, "R10 load data", r_res, exp_res);
                            else                  chk(r_res == exp_res, "R7 rmw result", r_res, exp_res);
                        end
                        if (v != 0) begin
                            chk(first_addr == sx, "R3 first address", first_addr, sx);
                            chk(mem[tgt] == exp_mem, "R7 target word", mem[tgt], exp_mem);
                        end else begin
                            chk(mem[fidx] == p1, "R8 memory untouched", mem[fidx], p1);
                        end
                    end
                end
            end
        end

        // R11: conflicting command held during busy is ignored
        lat = 1;
        poke(8'h10, 32'h0000_5151);
        poke(8'h30, 32'h0000_7777);
        run_cmd(2'd0, 2'd1, 16'h0010, 32'h0, 32'h0, 1'b1);
        chk(r_res == 32'h5151, "R11 result of first command", r_res, 32'h5151);
        chk(mem[8'h30] == 32'h7777, "R11 held store ignored", mem[8'h30], 32'h7777);
        chk(n_wr == 0, "R11 no write", 32'(n_wr), 32'h0);
        chk(!r_done_after && !r_busy_after, "R11 no second command",
            {30'b0, r_done_after, r_busy_after}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule